// File: doc/BRIEF.md
# Adaptive Home Lock Directory Entry

This block is the home-side record for one hardware lock in a directory-based shared memory machine. Nodes send it acquire, release and release-hint messages. It answers with grant, forwarded-request and acknowledge messages. While contention is light the entry runs centralized. It keeps the holder and an ordered list of up to `NWAIT` waiting nodes, and it hands the lock out strictly first-come first-served. Every release comes back to the home, so the lock is never cached at a node.

An acquire that finds the waiter list already full does not trap. The entry instead converts the queue into a distributed chain. In one step it tells the holder and each queued waiter who comes after them, then keeps only a tail pointer. Later acquires are forwarded to the current tail, and lock handover happens node to node. When a holder finds no successor, it sends a hint while still holding the lock. If the hinting node is still the tail, no request has been forwarded to it since, so the home acknowledges and the entry returns to centralized mode with that node as holder. Otherwise the hint is dropped.

Each input message is sampled on a rising clock edge. Its response appears on the output slots for exactly one cycle after that edge. Slot 0 carries every single-message response. All slots are used only for the chain built on a mode switch.

Top module: `adlock_home`

## Requirements
- R1: After reset the entry is centralized (`mode_dist`=0), the lock is free, `wait_cnt`=0 and no output slot is valid.
- R2: An acquire (`in_kind`=1) reaching a free centralized entry produces, one cycle later, only slot 0 valid with kind grant (`out_kind`=1) to the requester, and the requester becomes the holder.
- R3: An acquire reaching a held centralized entry with fewer than `NWAIT` waiters appends the requester to the waiter list, raises `wait_cnt` by one and sends nothing.
- R4: A release (`in_kind`=2) from the holder while waiters exist sends a grant in slot 0 to the oldest waiter, makes it the holder and lowers `wait_cnt` by one (FIFO order).
- R5: A release from the holder with no waiters frees the lock silently, so the next acquire is granted at once.
- R6: An acquire reaching a centralized entry with `NWAIT` waiters sets `mode_dist`=1 and `wait_cnt`=0, and marks all `NWAIT`+1 slots valid with kind forward (`out_kind`=2). Slot 0 goes to the holder naming the oldest waiter, slot k goes to waiter k-1 naming waiter k, and the last slot goes to the newest waiter naming the new requester. The requester becomes the tail.
- R7: An acquire in distributed mode sends a forward in slot 0 to the current tail naming the requester, and the requester becomes the tail.
- R8: An idle input (`in_kind`=0), a release in distributed mode, a release from a node that is not the holder, and a hint (`in_kind`=3) in centralized mode all leave mode, waiter list and holder unchanged and send nothing.
- R9: A hint in distributed mode from the current tail sends an acknowledge (`out_kind`=3) in slot 0 to that node and returns the entry to centralized mode with that node as holder. Its later release frees the lock.
- R10: A hint in distributed mode from any node other than the tail is dropped without reply, and the entry stays distributed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_kind | input | 2 | Incoming message: 0 idle, 1 acquire, 2 release, 3 hint |
| in_node | input | NODE_W | Sender of the incoming message |
| out_vld | output | NWAIT+1 | Valid bit per response slot |
| out_kind | output | (NWAIT+1)x2 | Per slot: 1 grant, 2 forward, 3 acknowledge |
| out_dst | output | (NWAIT+1)xNODE_W | Per slot destination node |
| out_arg | output | (NWAIT+1)xNODE_W | Per slot named node (requester for forwards) |
| mode_dist | output | 1 | 1 while the entry is in distributed mode |
| wait_cnt | output | clog2(NWAIT+1) | Number of queued waiters in centralized mode |

## Verification
The bound checker watches several invariants on every cycle: the waiter count stays within bounds and is zero in distributed mode, idle cycles stay quiet, a full list switches modes with every slot valid and each chain link points at the next slot's destination, distributed acquires always forward the requester, and an acknowledge always coincides with the return to centralized mode for the hinting node. Only the bench's scenarios show that grants follow arrival order across many releases, that ignored releases and stale hints leave the holder and the tail intact, and that a node acknowledged after a hint can later release and free the lock. It does so by driving long mixed message sequences against an independent model.

// File: rtl/adlock_pkg.sv
package adlock_pkg;

    typedef enum logic [1:0] {
        K_IDLE = 2'd0,
        K_ACQ  = 2'd1,
        K_REL  = 2'd2,
        K_HINT = 2'd3
    } in_kind_e;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_FWD   = 2'd2,
        RSP_ACK   = 2'd3
    } rsp_kind_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_GRANT,
        ACT_FWD,
        ACT_ACK,
        ACT_CHAIN
    } act_e;

    typedef enum logic {
        MODE_CENT = 1'b0,
        MODE_DIST = 1'b1
    } mode_e;

    function automatic rsp_kind_e act_to_rsp(act_e a);
        case (a)
            ACT_GRANT: return RSP_GRANT;
            ACT_FWD:   return RSP_FWD;
            ACT_CHAIN: return RSP_FWD;
            ACT_ACK:   return RSP_ACK;
            default:   return RSP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/adlock_wlist.sv
module adlock_wlist #(
    parameter int NODE_W = 4,
    parameter int NWAIT  = 4,
    localparam int CNT_W = $clog2(NWAIT + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push,
    input  logic [NODE_W-1:0]              push_id,
    input  logic                           pop,
    input  logic                           clear,
    output logic [NWAIT-1:0][NODE_W-1:0]   ents,
    output logic [CNT_W-1:0]               cnt
);

    logic [CNT_W-1:0] wr_idx;

    // Slot written by a push: behind the last entry, after any shift.
    assign wr_idx = pop ? (cnt - CNT_W'(1)) : cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
        end
    end

    for (genvar gi = 0; gi < NWAIT; gi++) begin : g_ent
        logic [NODE_W-1:0] ent_q;
        logic [NODE_W-1:0] shifted;

        if (gi < NWAIT - 1) begin : g_mid
            assign shifted = pop ? ents[gi+1] : ent_q;
        end else begin : g_last
            assign shifted = pop ? '0 : ent_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (push && wr_idx == CNT_W'(gi)) begin
                ent_q <= push_id;
            end else begin
                ent_q <= shifted;
            end
        end

        assign ents[gi] = ent_q;
    end

endmodule

// File: rtl/adlock_ctrl.sv
module adlock_ctrl
    import adlock_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int NWAIT  = 4,
    localparam int CNT_W = $clog2(NWAIT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  in_kind_e          in_kind,
    input  logic [NODE_W-1:0] in_node,
    input  logic [CNT_W-1:0]  wl_cnt,
    input  logic [NODE_W-1:0] wl_head,
    output logic              wl_push,
    output logic              wl_pop,
    output logic              wl_clear,
    output act_e              act,
    output logic [NODE_W-1:0] act_dst,
    output logic [NODE_W-1:0] act_arg,
    output logic [NODE_W-1:0] owner,
    output logic              mode_dist
);

    mode_e             mode_q, mode_n;
    logic              held_q, held_n;
    logic [NODE_W-1:0] owner_q, owner_n;
    logic [NODE_W-1:0] tail_q, tail_n;

    always_comb begin
        mode_n   = mode_q;
        held_n   = held_q;
        owner_n  = owner_q;
        tail_n   = tail_q;
        act      = ACT_NONE;
        act_dst  = '0;
        act_arg  = '0;
        wl_push  = 1'b0;
        wl_pop   = 1'b0;
        wl_clear = 1'b0;

        case (in_kind)
            K_ACQ: begin
                if (mode_q == MODE_CENT) begin
                    if (!held_q) begin
                        act     = ACT_GRANT;
                        act_dst = in_node;
                        act_arg = in_node;
                        held_n  = 1'b1;
                        owner_n = in_node;
                    end else if (wl_cnt < CNT_W'(NWAIT)) begin
                        wl_push = 1'b1;
                    end else begin
                        // list full: hand the queue over to the nodes
                        act      = ACT_CHAIN;
                        act_arg  = in_node;
                        wl_clear = 1'b1;
                        mode_n   = MODE_DIST;
                        tail_n   = in_node;
                        held_n   = 1'b0;
                    end
                end else begin
                    act     = ACT_FWD;
                    act_dst = tail_q;
                    act_arg = in_node;
                    tail_n  = in_node;
                end
            end
            K_REL: begin
                if (mode_q == MODE_CENT && held_q && in_node == owner_q) begin
                    if (wl_cnt != '0) begin
                        act     = ACT_GRANT;
                        act_dst = wl_head;
                        act_arg = wl_head;
                        wl_pop  = 1'b1;
                        owner_n = wl_head;
                    end else begin
                        held_n = 1'b0;
                    end
                end
            end
            K_HINT: begin
                // still the tail means nothing was forwarded to it since
                if (mode_q == MODE_DIST && in_node == tail_q) begin
                    act     = ACT_ACK;
                    act_dst = in_node;
                    act_arg = in_node;
                    mode_n  = MODE_CENT;
                    held_n  = 1'b1;
                    owner_n = in_node;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_CENT;
            held_q  <= 1'b0;
            owner_q <= '0;
            tail_q  <= '0;
        end else begin
            mode_q  <= mode_n;
            held_q  <= held_n;
            owner_q <= owner_n;
            tail_q  <= tail_n;
        end
    end

    assign owner     = owner_q;
    assign mode_dist = (mode_q == MODE_DIST);

endmodule

// File: rtl/adlock_emit.sv
module adlock_emit
    import adlock_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int NWAIT  = 4,
    localparam int NSLOT = NWAIT + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  act_e                          act,
    input  logic [NODE_W-1:0]             act_dst,
    input  logic [NODE_W-1:0]             act_arg,
    input  logic [NODE_W-1:0]             owner,
    input  logic [NWAIT-1:0][NODE_W-1:0]  ents,
    output logic [NSLOT-1:0]              out_vld,
    output logic [NSLOT-1:0][1:0]         out_kind,
    output logic [NSLOT-1:0][NODE_W-1:0]  out_dst,
    output logic [NSLOT-1:0][NODE_W-1:0]  out_arg
);

    logic chain;
    assign chain = (act == ACT_CHAIN);

    for (genvar gs = 0; gs < NSLOT; gs++) begin : g_slot
        logic              v;
        rsp_kind_e         k;
        logic [NODE_W-1:0] d;
        logic [NODE_W-1:0] a;
        logic              v_q;
        logic [1:0]        k_q;
        logic [NODE_W-1:0] d_q;
        logic [NODE_W-1:0] a_q;

        if (gs == 0) begin : g_first
            assign v = (act != ACT_NONE);
            assign k = act_to_rsp(act);
            assign d = chain ? owner : act_dst;
            assign a = chain ? ents[0] : act_arg;
        end else if (gs < NWAIT) begin : g_link
            assign v = chain;
            assign k = RSP_FWD;
            assign d = ents[gs-1];
            assign a = ents[gs];
        end else begin : g_end
            assign v = chain;
            assign k = RSP_FWD;
            assign d = ents[NWAIT-1];
            assign a = act_arg;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                k_q <= '0;
                d_q <= '0;
                a_q <= '0;
            end else begin
                v_q <= v;
                k_q <= v ? k : RSP_NONE;
                d_q <= v ? d : '0;
                a_q <= v ? a : '0;
            end
        end

        assign out_vld[gs]  = v_q;
        assign out_kind[gs] = k_q;
        assign out_dst[gs]  = d_q;
        assign out_arg[gs]  = a_q;
    end

endmodule

// File: rtl/adlock_home.sv
module adlock_home
    import adlock_pkg::*;
#(
    parameter int NODE_W = 4,
    parameter int NWAIT  = 4,
    localparam int NSLOT = NWAIT + 1,
    localparam int CNT_W = $clog2(NWAIT + 1)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [1:0]                   in_kind,
    input  logic [NODE_W-1:0]            in_node,
    output logic [NSLOT-1:0]             out_vld,
    output logic [NSLOT-1:0][1:0]        out_kind,
    output logic [NSLOT-1:0][NODE_W-1:0] out_dst,
    output logic [NSLOT-1:0][NODE_W-1:0] out_arg,
    output logic                         mode_dist,
    output logic [CNT_W-1:0]             wait_cnt
);

    logic                        wl_push, wl_pop, wl_clear;
    logic [NWAIT-1:0][NODE_W-1:0] wl_ents;
    act_e                        act;
    logic [NODE_W-1:0]           act_dst, act_arg, owner;

    adlock_wlist #(.NODE_W(NODE_W), .NWAIT(NWAIT)) u_wlist (
        .clk     (clk),
        .rst     (rst),
        .push    (wl_push),
        .push_id (in_node),
        .pop     (wl_pop),
        .clear   (wl_clear),
        .ents    (wl_ents),
        .cnt     (wait_cnt)
    );

    adlock_ctrl #(.NODE_W(NODE_W), .NWAIT(NWAIT)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_kind   (in_kind_e'(in_kind)),
        .in_node   (in_node),
        .wl_cnt    (wait_cnt),
        .wl_head   (wl_ents[0]),
        .wl_push   (wl_push),
        .wl_pop    (wl_pop),
        .wl_clear  (wl_clear),
        .act       (act),
        .act_dst   (act_dst),
        .act_arg   (act_arg),
        .owner     (owner),
        .mode_dist (mode_dist)
    );

    adlock_emit #(.NODE_W(NODE_W), .NWAIT(NWAIT)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .act_dst  (act_dst),
        .act_arg  (act_arg),
        .owner    (owner),
        .ents     (wl_ents),
        .out_vld  (out_vld),
        .out_kind (out_kind),
        .out_dst  (out_dst),
        .out_arg  (out_arg)
    );

endmodule

// File: rtl/adlock_home_chk.sv
module adlock_home_chk #(
    parameter int NODE_W = 4,
    parameter int NWAIT  = 4,
    localparam int NSLOT = NWAIT + 1,
    localparam int CNT_W = $clog2(NWAIT + 1)
) (
    input logic                         clk,
    input logic                         rst,
    input logic [1:0]                   in_kind,
    input logic [NODE_W-1:0]            in_node,
    input logic [NSLOT-1:0]             out_vld,
    input logic [NSLOT-1:0][1:0]        out_kind,
    input logic [NSLOT-1:0][NODE_W-1:0] out_dst,
    input logic [NSLOT-1:0][NODE_W-1:0] out_arg,
    input logic                         mode_dist,
    input logic [CNT_W-1:0]             wait_cnt
);

    p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mode_dist && wait_cnt == '0 && out_vld == '0));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        wait_cnt <= CNT_W'(NWAIT));

    p_dist_nolist_r6: assert property (@(posedge clk) disable iff (rst)
        mode_dist |-> wait_cnt == '0);

    p_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (!mode_dist && in_kind == 2'd1 && wait_cnt == CNT_W'(NWAIT))
        |=> (mode_dist && (&out_vld)));

    p_chain_link_r6: assert property (@(posedge clk) disable iff (rst)
        out_vld[1] |-> (out_kind[1] == 2'd2 && out_dst[1] == out_arg[0]));

    p_dist_fwd_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_dist && in_kind == 2'd1)
        |=> (out_vld[0] && out_kind[0] == 2'd2 && out_arg[0] == $past(in_node) && mode_dist));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (in_kind == 2'd0) |=> (out_vld == '0 && $stable(mode_dist) && $stable(wait_cnt)));

    p_ack_revert_r9: assert property (@(posedge clk) disable iff (rst)
        (out_vld[0] && out_kind[0] == 2'd3)
        |-> (!mode_dist && $past(mode_dist) && out_dst[0] == $past(in_node)));

endmodule

bind adlock_home adlock_home_chk #(.NODE_W(NODE_W), .NWAIT(NWAIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_kind   (in_kind),
    .in_node   (in_node),
    .out_vld   (out_vld),
    .out_kind  (out_kind),
    .out_dst   (out_dst),
    .out_arg   (out_arg),
    .mode_dist (mode_dist),
    .wait_cnt  (wait_cnt)
);

// File: tb/adlock_home_tb.sv
module adlock_home_tb;

    localparam int PERIOD = 10;
    localparam int NODE_W = 4;
    localparam int NWAIT  = 4;
    localparam int NSLOT  = NWAIT + 1;
    localparam int CNT_W  = 3;

    logic                         clk = 1'b0;
    logic                         rst = 1'b1;
    logic [1:0]                   in_kind = 2'd0;
    logic [NODE_W-1:0]            in_node = '0;
    logic [NSLOT-1:0]             out_vld;
    logic [NSLOT-1:0][1:0]        out_kind;
    logic [NSLOT-1:0][NODE_W-1:0] out_dst;
    logic [NSLOT-1:0][NODE_W-1:0] out_arg;
    logic                         mode_dist;
    logic [CNT_W-1:0]             wait_cnt;

    adlock_home #(.NODE_W(NODE_W), .NWAIT(NWAIT)) u_dut (
        .clk(clk), .rst(rst), .in_kind(in_kind), .in_node(in_node),
        .out_vld(out_vld), .out_kind(out_kind), .out_dst(out_dst),
        .out_arg(out_arg), .mode_dist(mode_dist), .wait_cnt(wait_cnt)
    );

    always #(PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    bit        m_dist, m_held;
    int        m_owner, m_tail, m_cnt;
    int        m_q [NWAIT];
    // expected response
    logic [NSLOT-1:0] e_vld;
    int        e_kind [NSLOT];
    int        e_dst  [NSLOT];
    int        e_arg  [NSLOT];
    string     e_tag;

    task automatic model_reset();
        m_dist = 0; m_held = 0; m_owner = 0; m_tail = 0; m_cnt = 0;
        for (int i = 0; i < NWAIT; i++) m_q[i] = 0;
    endtask

    task automatic set_slot(int s, int k, int d, int a);
        e_vld[s] = 1'b1; e_kind[s] = k; e_dst[s] = d; e_arg[s] = a;
    endtask

    task automatic model_step(int kind, int node);
        e_vld = '0;
        for (int i = 0; i < NSLOT; i++) begin
            e_kind[i] = 0; e_dst[i] = 0; e_arg[i] = 0;
        end
        e_tag = "R8";
        if (kind == 1) begin
            if (!m_dist) begin
                if (!m_held) begin
                    set_slot(0, 1, node, node);
                    m_held = 1; m_owner = node; e_tag = "R2";
                end else if (m_cnt < NWAIT) begin
                    m_q[m_cnt] = node; m_cnt++; e_tag = "R3";
                end else begin
                    set_slot(0, 2, m_owner, m_q[0]);
                    for (int s = 1; s < NWAIT; s++) set_slot(s, 2, m_q[s-1], m_q[s]);
                    set_slot(NWAIT, 2, m_q[NWAIT-1], node);
                    m_dist = 1; m_tail = node; m_cnt = 0; m_held = 0; e_tag = "R6";
                end
            end else begin
                set_slot(0, 2, m_tail, node);
                m_tail = node; e_tag = "R7";
            end
        end else if (kind == 2) begin
            if (!m_dist && m_held && node == m_owner) begin
                if (m_cnt > 0) begin
                    set_slot(0, 1, m_q[0], m_q[0]);
                    m_owner = m_q[0];
                    for (int i = 0; i < NWAIT - 1; i++) m_q[i] = m_q[i+1];
                    m_q[NWAIT-1] = 0;
                    m_cnt--; e_tag = "R4";
                end else begin
                    m_held = 0; e_tag = "R5";
                end
            end
        end else if (kind == 3) begin
            if (m_dist) begin
                if (node == m_tail) begin
                    set_slot(0, 3, node, node);
                    m_dist = 0; m_held = 1; m_owner = node; e_tag = "R9";
                end else begin
                    e_tag = "R10";
                end
            end
        end
    endtask

    task automatic compare(string tag);
        bit ok = 1'b1;
        total++;
        if (mode_dist !== m_dist || wait_cnt !== CNT_W'(m_cnt)) ok = 1'b0;
        if (out_vld !== e_vld) ok = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (e_vld[s] && (int'(out_kind[s]) != e_kind[s] || int'(out_dst[s]) != e_dst[s]
                             || int'(out_arg[s]) != e_arg[s])) ok = 1'b0;
        end
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual mode=%0d cnt=%0d vld=%b s0=%0d/%0d/%0d expected mode=%0d cnt=%0d vld=%b s0=%0d/%0d/%0d",
                     tag, mode_dist, wait_cnt, out_vld, out_kind[0], out_dst[0], out_arg[0],
                     m_dist, m_cnt, e_vld, e_kind[0], e_dst[0], e_arg[0]);
        end
    endtask

    // drive at a falling edge, check at the next one
    task automatic send(int kind, int node);
        in_kind = 2'(kind);
        in_node = NODE_W'(node);
        model_step(kind, node);
        @(negedge clk);
        compare(e_tag);
    endtask

    initial begin
        void'($urandom(32'd7031));
        model_reset();
        e_vld = '0;
        for (int i = 0; i < NSLOT; i++) begin
            e_kind[i] = 0; e_dst[i] = 0; e_arg[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1");                  // reset state

        send(1, 1);                     // R2 grant on free lock
        send(1, 2);                     // R3 queue
        send(1, 3);
        send(1, 4);
        send(1, 5);                     // R3 list now full
        send(2, 9);                     // R8 non-holder release ignored
        send(2, 1);                     // R4 oldest waiter granted
        send(1, 6);                     // R3 refill
        send(1, 7);                     // R6 switch and chain
        send(1, 8);                     // R7 forward to tail
        send(2, 8);                     // R8 release in distributed mode
        send(3, 7);                     // R10 stale hint dropped
        send(3, 8);                     // R9 acknowledge, back to centralized
        send(3, 8);                     // R8 hint in centralized mode
        send(1, 9);                     // R3 queued behind node 8
        send(2, 8);                     // R4 grant to 9
        send(2, 9);                     // R5 lock freed
        send(1, 10);                    // R2 granted at once
        send(0, 0);                     // R8 idle

        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(0, 99));
            int kind;
            int node = int'($urandom_range(0, 15));
            if (r < 50) kind = 1;
            else if (r < 75) kind = 2;
            else if (r < 90) kind = 3;
            else kind = 0;
            if (kind == 2 && $urandom_range(0, 9) < 8) node = m_owner;
            if (kind == 3 && m_dist && $urandom_range(0, 9) < 6) node = m_tail;
            send(kind, node);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule